// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Sequencer

This block is the digital side of a multi-channel successive-approximation converter. A single start request converts every enabled channel once, from the lowest channel index to the highest, and the block then returns to idle. A start comes from a software strobe or from a rising edge on one selectable hardware trigger input. Both sources stay live together. For each channel, the block selects the channel and waits a programmable sample-and-hold time. It then pulses a convert request to the external converter and captures the result when the converter reports completion.

In low-power mode the block turns the analog cell on only for the length of a sequence. A start raises the power enable and waits a programmable warm-up time before the first channel. The power enable drops when the last result has been handed off. Any start that arrives while a sequence runs is discarded. Results leave on a valid/ready stream. The stream holds one result at a time. When that result has not been taken, the sequencer stalls before it selects the next channel, so no result is lost and no result is overwritten.

Both waits are counted in ticks of a prescaled clock. A prescale value P gives one tick every P+1 clock cycles. A wait field value N lasts N+1 ticks. The prescaler restarts at the beginning of every wait.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A start is taken in idle when `sw_start` is high, or when `cfg_trig_en` is high and the input `hw_trig[cfg_trig_sel]` is high after having been low in the previous cycle. Holding a trigger high starts only one sequence. Unselected trigger inputs have no effect, and hardware triggers have no effect while `cfg_trig_en` is low.
- R2: A sequence visits only the channels that were enabled when it started, in ascending index order. For each channel it drives `conv_ch` to that index and gives exactly one single-cycle `conv_req` pulse. After the last channel's result is handed to the stream, `busy` drops.
- R3: `ch_enabled` resets to zero. A 1 in `ch_set` enables that channel and a 1 in `ch_clr` disables it, both from the next cycle on. When both bits are set for the same channel in the same cycle, the clear wins.
- R4: A channel's `conv_req` appears (S+1)*(P+1) cycles after the edge at which the channel is selected, where S = `cfg_shold` and P = `cfg_prescale`. After a result is captured, the next channel is selected one cycle later if the stream slot is free.
- R5: With `cfg_sleep` = 1, `ana_pwr_en` is low in idle. It rises at the edge that takes the start. The first channel is selected (U+1)*(P+1) cycles later, where U = `cfg_startup`. `ana_pwr_en` falls when `busy` falls.
- R6: With `cfg_sleep` = 0, `ana_pwr_en` is always high and no warm-up wait is inserted: the first channel is selected at the edge that takes the start.
- R7: Starts that arrive while `busy` is high are dropped and not queued.
- R8: A start with no channel enabled leaves `busy` low and produces no `conv_req` and no `m_valid`.
- R9: Once `m_valid` is high it stays high, with `m_data` and `m_ch` unchanged, until a cycle with `m_ready` high. While the slot is full, no further channel is selected.
- R10: Each accepted stream beat carries the converter word captured for one channel in `m_data` and that channel's index in `m_ch`. Beats come out in conversion order, and there is exactly one beat per converted channel.
- R11: After reset the block is idle: `busy`, `conv_req` and `m_valid` are low and no channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sleep | input | 1 | Low-power mode: analog power enable only during sequences |
| cfg_prescale | input | PRE_W | Tick divider; a tick every value+1 cycles |
| cfg_startup | input | WAIT_W | Warm-up wait in ticks minus one |
| cfg_shold | input | WAIT_W | Sample-and-hold wait in ticks minus one |
| cfg_trig_en | input | 1 | Enables the hardware trigger path |
| cfg_trig_sel | input | TSEL_W | Index of the hardware trigger input used |
| hw_trig | input | TRIG_N | Hardware trigger inputs, rising edge active |
| sw_start | input | 1 | Software start strobe |
| ch_set | input | NUM_CH | Write-one-to-set channel enable |
| ch_clr | input | NUM_CH | Write-one-to-clear channel enable |
| ch_enabled | output | NUM_CH | Current channel enable mask |
| busy | output | 1 | High while a sequence is running |
| ana_pwr_en | output | 1 | Analog cell power enable |
| conv_req | output | 1 | Single-cycle convert request |
| conv_ch | output | CH_W | Channel currently selected |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | DATA_W | Converter result word |
| m_valid | output | 1 | Stream result valid |
| m_ready | input | 1 | Stream consumer ready |
| m_data | output | DATA_W | Stream result word |
| m_ch | output | CH_W | Channel index of the stream result |

## Verification
The bench builds the block with four channels, two trigger inputs, 8-bit results and 2-bit prescale and wait fields. With these sizes every channel mask (all sixteen, the empty one included) can be crossed with every prescale, sample-and-hold and warm-up value from 0 to 2, in both power modes and from both start sources. This lets the bench compute the exact cycle of every convert request from the tick formulas. Directed cases then cover a stalled stream, trigger bursts during a sequence, trigger gating and selection, and set/clear conflicts.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STARTUP,
    ST_SHOLD,
    ST_CONVERT,
    ST_PUSH
  } seq_state_e;

endpackage

// File: rtl/adc_trig_detect.sv
module adc_trig_detect #(
  parameter int TRIG_N = 4,
  localparam int TSEL_W = (TRIG_N > 1) ? $clog2(TRIG_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRIG_N-1:0] hw_trig,
  input  logic [TSEL_W-1:0] trig_sel,
  input  logic              trig_en,
  input  logic              sw_start,
  output logic              start_req
);

  logic sel_now;
  logic sel_prev;
  logic hw_rise;

  always_comb begin
    sel_now = 1'b0;
    for (int i = 0; i < TRIG_N; i++) begin
      if (trig_sel == TSEL_W'(i)) sel_now = hw_trig[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_prev <= 1'b1;
    else        sel_prev <= sel_now;
  end

  assign hw_rise   = sel_now & ~sel_prev;
  assign start_req = sw_start | (trig_en & hw_rise);

  AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rise |=> !hw_rise); // R1

endmodule

// File: rtl/adc_ch_mask.sv
module adc_ch_mask #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_set,
  input  logic [NUM_CH-1:0] ch_clr,
  output logic [NUM_CH-1:0] mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= (mask | ch_set) & ~ch_clr;
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_clr) |=> ((mask & $past(ch_clr)) == '0)); // R3

endmodule

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
  parameter int PRE_W  = 8,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [WAIT_W-1:0] limit,
  output logic              done
);

  logic [PRE_W-1:0]  pcnt;
  logic [WAIT_W-1:0] wcnt;
  logic              tick;

  assign tick = (pcnt == prescale);
  assign done = tick && (wcnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      wcnt <= '0;
    end else if (restart) begin
      pcnt <= '0;
      wcnt <= '0;
    end else if (tick) begin
      pcnt <= '0;
      wcnt <= wcnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

endmodule

// File: rtl/adc_result_slot.sv
module adc_result_slot #(
  parameter int DATA_W = 12,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [CH_W-1:0]   load_ch,
  output logic              free,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [CH_W-1:0]   m_ch
);

  assign free = !m_valid || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_ch    <= '0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= load_data;
      m_ch    <= load_ch;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_ch))); // R9

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 12,
  parameter int PRE_W  = 8,
  parameter int WAIT_W = 8,
  parameter int TRIG_N = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int TSEL_W = (TRIG_N > 1) ? $clog2(TRIG_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sleep,
  input  logic [PRE_W-1:0]  cfg_prescale,
  input  logic [WAIT_W-1:0] cfg_startup,
  input  logic [WAIT_W-1:0] cfg_shold,
  input  logic              cfg_trig_en,
  input  logic [TSEL_W-1:0] cfg_trig_sel,
  input  logic [TRIG_N-1:0] hw_trig,
  input  logic              sw_start,
  input  logic [NUM_CH-1:0] ch_set,
  input  logic [NUM_CH-1:0] ch_clr,
  output logic [NUM_CH-1:0] ch_enabled,
  output logic              busy,
  output logic              ana_pwr_en,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [CH_W-1:0]   m_ch
);

  seq_state_e        state;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] pick_src;
  logic [CH_W-1:0]   pick_ch;
  logic [CH_W-1:0]   cur_ch;
  logic [DATA_W-1:0] cap_data;
  logic              pwr_on;
  logic              start_req;
  logic              go;
  logic              wait_done;
  logic              timer_restart;
  logic [WAIT_W-1:0] wait_limit;
  logic              slot_free;
  logic              slot_load;
  logic              more;

  adc_trig_detect #(.TRIG_N(TRIG_N)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_trig   (hw_trig),
    .trig_sel  (cfg_trig_sel),
    .trig_en   (cfg_trig_en),
    .sw_start  (sw_start),
    .start_req (start_req)
  );

  adc_ch_mask #(.NUM_CH(NUM_CH)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .ch_set (ch_set),
    .ch_clr (ch_clr),
    .mask   (ch_enabled)
  );

  adc_wait_timer #(.PRE_W(PRE_W), .WAIT_W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (timer_restart),
    .prescale (cfg_prescale),
    .limit    (wait_limit),
    .done     (wait_done)
  );

  adc_result_slot #(.DATA_W(DATA_W), .CH_W(CH_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (slot_load),
    .load_data (cap_data),
    .load_ch   (cur_ch),
    .free      (slot_free),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data),
    .m_ch      (m_ch)
  );

  // Lowest set channel of the active source mask.
  assign pick_src = (state == ST_IDLE) ? ch_enabled : pending;

  always_comb begin
    pick_ch = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pick_src[i]) pick_ch = CH_W'(i);
    end
  end

  assign go         = (state == ST_IDLE) && start_req && (|ch_enabled);
  assign more       = |pending;
  assign slot_load  = (state == ST_PUSH) && slot_free;
  assign wait_limit = (state == ST_STARTUP) ? cfg_startup : cfg_shold;

  assign timer_restart = go
                      || ((state == ST_STARTUP) && wait_done)
                      || (slot_load && more);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pending  <= '0;
      cur_ch   <= '0;
      cap_data <= '0;
      conv_req <= 1'b0;
      pwr_on   <= 1'b0;
    end else begin
      conv_req <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (go) begin
            if (cfg_sleep) begin
              pwr_on  <= 1'b1;
              pending <= ch_enabled;
              state   <= ST_STARTUP;
            end else begin
              cur_ch  <= pick_ch;
              pending <= ch_enabled & ~(NUM_CH'(1) << pick_ch);
              state   <= ST_SHOLD;
            end
          end
        end
        ST_STARTUP: begin
          if (wait_done) begin
            cur_ch  <= pick_ch;
            pending <= pending & ~(NUM_CH'(1) << pick_ch);
            state   <= ST_SHOLD;
          end
        end
        ST_SHOLD: begin
          if (wait_done) begin
            conv_req <= 1'b1;
            state    <= ST_CONVERT;
          end
        end
        ST_CONVERT: begin
          if (conv_done) begin
            cap_data <= conv_data;
            state    <= ST_PUSH;
          end
        end
        ST_PUSH: begin
          if (slot_free) begin
            if (more) begin
              cur_ch  <= pick_ch;
              pending <= pending & ~(NUM_CH'(1) << pick_ch);
              state   <= ST_SHOLD;
            end else begin
              pwr_on <= 1'b0;
              state  <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign ana_pwr_en = !cfg_sleep || pwr_on;
  assign conv_ch    = cur_ch;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req); // R2

  AST_BUSY_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ana_pwr_en); // R5

  AST_EMPTY_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ch_enabled == '0) |=> !busy); // R8

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> busy); // R7

endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

  localparam int NCH = 4;
  localparam int DW  = 8;
  localparam int CW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_sleep = 1'b0;
  logic [1:0]    cfg_prescale = '0;
  logic [1:0]    cfg_startup = '0;
  logic [1:0]    cfg_shold = '0;
  logic          cfg_trig_en = 1'b0;
  logic [0:0]    cfg_trig_sel = '0;
  logic [1:0]    hw_trig = '0;
  logic          sw_start = 1'b0;
  logic [NCH-1:0] ch_set = '0;
  logic [NCH-1:0] ch_clr = '0;
  logic [NCH-1:0] ch_enabled;
  logic          busy, ana_pwr_en, conv_req, conv_done = 1'b0;
  logic [CW-1:0] conv_ch;
  logic [DW-1:0] conv_data = '0;
  logic          m_valid, m_ready = 1'b1;
  logic [DW-1:0] m_data;
  logic [CW-1:0] m_ch;

  int n_cmp = 0;
  int n_bad = 0;
  int req_n = 0;
  int hs_n  = 0;
  logic [5:0]    tag = '0;
  logic [CW-1:0] hs_ch [64];
  logic [DW-1:0] hs_dat[64];

  always #2.5 clk = ~clk;

  adc_seq_ctrl #(.NUM_CH(NCH), .DATA_W(DW), .PRE_W(2), .WAIT_W(2), .TRIG_N(2)) i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_sleep(cfg_sleep), .cfg_prescale(cfg_prescale),
    .cfg_startup(cfg_startup), .cfg_shold(cfg_shold), .cfg_trig_en(cfg_trig_en),
    .cfg_trig_sel(cfg_trig_sel), .hw_trig(hw_trig), .sw_start(sw_start),
    .ch_set(ch_set), .ch_clr(ch_clr), .ch_enabled(ch_enabled), .busy(busy),
    .ana_pwr_en(ana_pwr_en), .conv_req(conv_req), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .m_ch(m_ch)
  );

  // Converter model: answers every request one cycle later.
  always @(negedge clk) begin
    conv_done <= conv_req;
    conv_data <= {tag, conv_ch};
  end

  // Edge monitor: requests and accepted stream beats.
  always @(posedge clk) begin
    if (rst_n && conv_req) req_n <= req_n + 1;
    if (rst_n && m_valid && m_ready) begin
      hs_ch[hs_n % 64]  <= m_ch;
      hs_dat[hs_n % 64] <= m_data;
      hs_n <= hs_n + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic program_mask(input logic [NCH-1:0] m);
    ch_clr = '1;
    step();
    ch_clr = '0;
    ch_set = m;
    step();
    ch_set = '0;
  endtask

  task automatic run_seq(input logic [NCH-1:0] mask, input bit slp,
                         input int p, input int s, input int u, input bit hw);
    int n, exp, last, base_r, base_h, cnt, k;
    int exp_ch[4];
    string rpw;
    rpw = slp ? "R5" : "R6";
    cfg_sleep = slp;
    cfg_prescale = 2'(p);
    cfg_shold = 2'(s);
    cfg_startup = 2'(u);
    cfg_trig_en = 1'b1;
    cfg_trig_sel = 1'b1;
    tag = tag + 1'b1;
    program_mask(mask);
    chk("R3 mask", int'(ch_enabled), int'(mask));
    chk("R2 idle", int'(busy), 0);
    chk({rpw, " idle pwr"}, int'(ana_pwr_en), int'(!slp));
    base_r = req_n;
    base_h = hs_n;
    if (hw) hw_trig[1] = 1'b1;
    else    sw_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sw_start = 1'b0;
    n = 0;
    if (mask == '0) begin
      repeat (8) step();
      chk("R8 busy", int'(busy), 0);
      chk("R8 reqs", req_n - base_r, 0);
      chk("R8 beats", hs_n - base_h, 0);
      hw_trig = '0;
      step();
      return;
    end
    chk("R1 started", int'(busy), 1);
    chk({rpw, " pwr at start"}, int'(ana_pwr_en), 1);
    exp = (slp ? (u + 1) * (p + 1) : 0) + (s + 1) * (p + 1);
    cnt = 0;
    last = 0;
    for (int c = 0; c < NCH; c++) begin
      if (mask[c]) begin
        k = 0;
        while (!conv_req && k < 400) begin
          step();
          n++;
          k++;
        end
        chk((cnt == 0) ? {rpw, " first req cycle"} : "R4 req cycle", n, exp);
        chk("R2 channel", int'(conv_ch), c);
        exp_ch[cnt] = c;
        cnt++;
        last = n;
        exp = n + 2 + (s + 1) * (p + 1);
        step();
        n++;
      end
    end
    step();
    chk("R2 done busy", int'(busy), 0);
    chk({rpw, " pwr after"}, int'(ana_pwr_en), int'(!slp));
    step();
    chk("R2 req count", req_n - base_r, cnt);
    chk("R10 beat count", hs_n - base_h, cnt);
    for (int i = 0; i < cnt; i++) begin
      chk("R10 beat ch", int'(hs_ch[(base_h + i) % 64]), exp_ch[i]);
      chk("R10 beat data", int'(hs_dat[(base_h + i) % 64]), int'({tag, 2'(exp_ch[i])}));
    end
    hw_trig = '0;
    step();
  endtask

  initial begin
    int base_r, base_h, k;
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R11 mask", int'(ch_enabled), 0);
    chk("R11 busy", int'(busy), 0);
    chk("R11 req", int'(conv_req), 0);
    chk("R11 valid", int'(m_valid), 0);

    // Set/clear registers: clear wins on conflict.
    ch_set = 4'b0101; step();
    ch_set = 4'b0010; step();
    chk("R3 set accumulate", int'(ch_enabled), 7);
    ch_set = 4'b0001; ch_clr = 4'b0011; step();
    ch_set = '0; ch_clr = '0;
    chk("R3 clear wins", int'(ch_enabled), 4);

    // Sweep over masks, timing fields, modes and sources.
    for (int slp = 0; slp < 2; slp++)
      for (int p = 0; p < 3; p++)
        for (int s = 0; s < 3; s++)
          for (int u = 0; u < (slp ? 3 : 1); u++)
            for (int m = 0; m < 16; m++)
              run_seq(4'(m), slp[0], p, s, u, m[0] ^ slp[0]);

    // Trigger gating and selection.
    cfg_sleep = 1'b0; cfg_prescale = '0; cfg_shold = '0;
    program_mask(4'b0001);
    cfg_trig_en = 1'b0; cfg_trig_sel = 1'b1;
    base_r = req_n;
    hw_trig[1] = 1'b1; repeat (20) step();
    chk("R1 trig disabled", req_n - base_r, 0);
    hw_trig = '0; step();
    cfg_trig_en = 1'b1;
    hw_trig[0] = 1'b1; repeat (20) step();
    chk("R1 unselected input", req_n - base_r, 0);
    hw_trig = '0; step();
    hw_trig[1] = 1'b1; repeat (40) step();
    chk("R1 held level one start", req_n - base_r, 1);
    hw_trig = '0; step();

    // Starts during a sequence are dropped.
    cfg_prescale = 2'd1; cfg_shold = 2'd2;
    program_mask(4'b1111);
    base_r = req_n;
    sw_start = 1'b1; step(); sw_start = 1'b0;
    k = 0;
    while (busy && k < 400) begin
      sw_start = (k % 3 == 0);
      hw_trig[1] = ((k / 4) % 2 == 1);
      step();
      k++;
    end
    sw_start = 1'b0; hw_trig = '0;
    repeat (30) step();
    chk("R7 dropped starts", req_n - base_r, 4);
    chk("R7 idle after", int'(busy), 0);

    // Back-pressure stall.
    cfg_prescale = '0; cfg_shold = '0;
    program_mask(4'b0111);
    tag = tag + 1'b1;
    base_r = req_n; base_h = hs_n;
    m_ready = 1'b0;
    sw_start = 1'b1; step(); sw_start = 1'b0;
    repeat (40) step();
    chk("R9 stalled reqs", req_n - base_r, 2);
    chk("R9 valid held", int'(m_valid), 1);
    chk("R9 first ch", int'(m_ch), 0);
    chk("R9 busy stalled", int'(busy), 1);
    held = m_data;
    repeat (10) step();
    chk("R9 data stable", int'(m_data), int'(held));
    m_ready = 1'b1;
    repeat (40) step();
    chk("R9 reqs after release", req_n - base_r, 3);
    chk("R9 beats after release", hs_n - base_h, 3);
    chk("R10 last ch", int'(hs_ch[(base_h + 2) % 64]), 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule